// File: doc/BRIEF.md
# Load-Store Address and Stack Unit

This block turns one decoded data-transfer operation per cycle into memory strobes, a word address, store data and a register write-back choice. It handles a move whose 3-bit mode field picks one of eight source and destination combinations, an effective-address load that never touches memory, and push and pop on a stack that grows toward lower addresses. The stack pointer is held inside the unit. Every access is checked against a fixed memory map before it leaves the block.

An operation presented with `valid_i` high produces its results on the registered outputs one clock later. A bad access or a stack fault raises `err_o` with a code, and it also suppresses every strobe, the write-back and the stack-pointer update for that operation. The memory arrays and the register file sit outside the unit. All addresses are word addresses, and address arithmetic wraps modulo 2^32.

Top module: `lsu_stack_unit`

## Requirements
- R1: After reset the stack pointer equals RAM_WORDS-1 (0x003FFFFF by default, the last RAM word), and no strobe, write-back or error is active.
- R2: Op class MOVE (op_i=0) with mode 0 writes back the immediate (wb_sel_o=0), and with mode 1 writes back reg2_i (wb_sel_o=1). Neither mode issues a memory access.
- R3: MOVE modes 2, 3 and 4 read memory at imm_i, reg2_i and reg2_i+imm_i respectively, and write the loaded word back (wb_sel_o=2).
- R4: MOVE modes 5, 6 and 7 store reg2_i at imm_i, reg1_i and reg1_i+imm_i respectively, with no write-back. A read strobe and a write strobe are never active together.
- R5: Op class LEA (op_i=1) writes back reg2_i+imm_i (wb_sel_o=3) and issues no memory access.
- R6: Op class PUSH (op_i=2) stores reg1_i at address SP-1 and decrements the stack pointer by one.
- R7: Op class POP (op_i=3) reads memory at address SP, writes the word back (wb_sel_o=2) and increments the stack pointer by one.
- R8: A push with SP equal to 0 reports error code 4 and issues no store. The stack pointer is left unchanged.
- R9: A pop with SP equal to RAM_WORDS-1 reports error code 5 and issues no read. The stack pointer is left unchanged.
- R10: A read outside RAM [0, RAM_WORDS), the system ROM at 0x10000000, the cartridge ROM at 0x20000000 and the memory card at 0x30000000 (each sized by a parameter) reports error code 0. The read is suppressed and there is no write-back.
- R11: A write to either ROM region, or to an unmapped address, reports error code 1 and the store is suppressed.
- R12: Reads from both ROM regions and from the memory card succeed. Writes to RAM and to the memory card succeed.
- R13: A cycle with valid_i low produces no strobe, no write-back and no error, and it leaves the stack pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | Op class: 0 move, 1 LEA, 2 push, 3 pop |
| mode_i | input | 3 | Addressing mode for a move |
| reg1_i | input | 32 | First register operand |
| reg2_i | input | 32 | Second register operand |
| imm_i | input | 32 | Immediate operand |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Store data |
| wb_en_o | output | 1 | Write the first register |
| wb_sel_o | output | 2 | Write-back source: 0 imm, 1 reg2, 2 memory, 3 address |
| wb_data_o | output | 32 | Write-back value for sources 0, 1 and 3 |
| err_o | output | 1 | Access or stack fault |
| err_code_o | output | 4 | Fault code: 0 read, 1 write, 4 overflow, 5 underflow |
| sp_o | output | 32 | Current stack pointer |

## Verification
Each of the eight move modes is driven with distinct register and immediate values, so a swapped operand or an offset that is dropped shows up as a wrong address or wrong data. The bench also uses a base near 2^32 to exercise the wrap. A run of pushes walks the stack pointer from the top of a small RAM down to zero and then one step further, and pops at both ends separate overflow from underflow. Addresses just past the end of each region, inside each ROM and inside the card, are tried as both reads and writes. This separates the read-only regions from the writable ones and the mapped regions from the gaps.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned NUM_REGIONS = 4;

  typedef enum logic [1:0] {
    OP_MOVE = 2'd0,
    OP_LEA  = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    WB_IMM  = 2'd0,
    WB_REG2 = 2'd1,
    WB_MEM  = 2'd2,
    WB_ADDR = 2'd3
  } wb_sel_e;

  localparam logic [3:0] ERR_BAD_READ  = 4'd0;
  localparam logic [3:0] ERR_BAD_WRITE = 4'd1;
  localparam logic [3:0] ERR_OVERFLOW  = 4'd4;
  localparam logic [3:0] ERR_UNDERFLOW = 4'd5;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] wdata;
    logic              wb_en;
    wb_sel_e           wb_sel;
    logic [ADDR_W-1:0] wb_data;
  } xfer_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] reg1_i,
  input  logic [ADDR_W-1:0] reg2_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] sp_i,
  output xfer_t             xfer_o
);
  logic [ADDR_W-1:0] r1_off, r2_off;

  assign r1_off = reg1_i + imm_i;
  assign r2_off = reg2_i + imm_i;

  always_comb begin
    xfer_o = '0;
    unique case (op_e'(op_i))
      OP_MOVE: begin
        unique case (mode_i)
          3'd0: begin
            xfer_o.wb_en = 1'b1; xfer_o.wb_sel = WB_IMM; xfer_o.wb_data = imm_i;
          end
          3'd1: begin
            xfer_o.wb_en = 1'b1; xfer_o.wb_sel = WB_REG2; xfer_o.wb_data = reg2_i;
          end
          3'd2, 3'd3, 3'd4: begin
            xfer_o.rd = 1'b1; xfer_o.wb_en = 1'b1; xfer_o.wb_sel = WB_MEM;
            xfer_o.addr = (mode_i == 3'd2) ? imm_i :
                          (mode_i == 3'd3) ? reg2_i : r2_off;
          end
          default: begin
            xfer_o.wr = 1'b1; xfer_o.wdata = reg2_i;
            xfer_o.addr = (mode_i == 3'd5) ? imm_i :
                          (mode_i == 3'd6) ? reg1_i : r1_off;
          end
        endcase
      end
      OP_LEA: begin
        xfer_o.wb_en = 1'b1; xfer_o.wb_sel = WB_ADDR; xfer_o.wb_data = r2_off;
      end
      OP_PUSH: begin
        xfer_o.push = 1'b1; xfer_o.wr = 1'b1;
        xfer_o.addr = sp_i - 1'b1; xfer_o.wdata = reg1_i;
      end
      default: begin
        xfer_o.pop = 1'b1; xfer_o.rd = 1'b1;
        xfer_o.addr = sp_i; xfer_o.wb_en = 1'b1; xfer_o.wb_sel = WB_MEM;
      end
    endcase
  end
endmodule

// File: rtl/lsu_map_check.sv
module lsu_map_check
  import lsu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_WORDS  = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] BIOS_BASE  = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] BIOS_WORDS = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] CART_BASE  = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] CART_WORDS = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] CARD_BASE  = 32'h3000_0000,
  parameter logic [ADDR_W-1:0] CARD_WORDS = 32'h0004_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);
  localparam logic [ADDR_W-1:0] BASES [NUM_REGIONS] =
    '{32'h0, BIOS_BASE, CART_BASE, CARD_BASE};
  localparam logic [ADDR_W-1:0] SIZES [NUM_REGIONS] =
    '{RAM_WORDS, BIOS_WORDS, CART_WORDS, CARD_WORDS};
  // bit i set: region i accepts stores (RAM and card)
  localparam logic [NUM_REGIONS-1:0] WRITABLE = 4'b1001;

  logic [NUM_REGIONS-1:0] hit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [ADDR_W-1:0] rel;
    assign rel    = addr_i - BASES[g];
    assign hit[g] = (addr_i >= BASES[g]) && (rel < SIZES[g]);
  end

  assign rd_ok_o = |hit;
  assign wr_ok_o = |(hit & WRITABLE);

  AST_WR_NEEDS_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> rd_ok_o); // R12
  AST_ONE_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R10
endmodule

// File: rtl/lsu_stack_ptr.sv
module lsu_stack_ptr
  import lsu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_WORDS = 32'h0040_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              at_floor_o,
  output logic              at_top_o
);
  localparam logic [ADDR_W-1:0] SP_TOP = RAM_WORDS - 1'b1;

  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_TOP;
    else if (dec_i) sp_q <= sp_q - 1'b1;
    else if (inc_i) sp_q <= sp_q + 1'b1;
  end

  assign sp_o       = sp_q;
  assign at_floor_o = (sp_q == '0);
  assign at_top_o   = (sp_q == SP_TOP);

  AST_SP_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_q == $past(sp_q)) || (sp_q == $past(sp_q) + 1) || (sp_q == $past(sp_q) - 1)); // R6
  AST_SP_NO_WRAP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> sp_q != '0); // R8
  AST_SP_NO_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> sp_q != SP_TOP); // R9
endmodule

// File: rtl/lsu_stack_unit.sv
module lsu_stack_unit
  import lsu_pkg::*;
#(
  parameter logic [31:0] RAM_WORDS  = 32'h0040_0000,
  parameter logic [31:0] BIOS_BASE  = 32'h1000_0000,
  parameter logic [31:0] BIOS_WORDS = 32'h0010_0000,
  parameter logic [31:0] CART_BASE  = 32'h2000_0000,
  parameter logic [31:0] CART_WORDS = 32'h0800_0000,
  parameter logic [31:0] CARD_BASE  = 32'h3000_0000,
  parameter logic [31:0] CARD_WORDS = 32'h0004_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [1:0]  op_i,
  input  logic [2:0]  mode_i,
  input  logic [31:0] reg1_i,
  input  logic [31:0] reg2_i,
  input  logic [31:0] imm_i,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        wb_en_o,
  output logic [1:0]  wb_sel_o,
  output logic [31:0] wb_data_o,
  output logic        err_o,
  output logic [3:0]  err_code_o,
  output logic [31:0] sp_o
);
  xfer_t             xfer;
  logic [ADDR_W-1:0] sp;
  logic              at_floor, at_top, rd_ok, wr_ok;
  logic              stk_err, map_err, fault, go;
  logic [3:0]        code_d;

  lsu_addr_gen u_addr (
    .op_i   (op_i),
    .mode_i (mode_i),
    .reg1_i (reg1_i),
    .reg2_i (reg2_i),
    .imm_i  (imm_i),
    .sp_i   (sp),
    .xfer_o (xfer)
  );

  lsu_map_check #(
    .RAM_WORDS (RAM_WORDS),  .BIOS_BASE (BIOS_BASE), .BIOS_WORDS (BIOS_WORDS),
    .CART_BASE (CART_BASE),  .CART_WORDS (CART_WORDS),
    .CARD_BASE (CARD_BASE),  .CARD_WORDS (CARD_WORDS)
  ) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (xfer.addr),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok)
  );

  // stack faults take priority over map faults
  always_comb begin
    stk_err = (xfer.push && at_floor) || (xfer.pop && at_top);
    map_err = (xfer.rd && !rd_ok) || (xfer.wr && !wr_ok);
    fault   = valid_i && (stk_err || map_err);
    go      = valid_i && !fault;
    if (xfer.push && at_floor)    code_d = ERR_OVERFLOW;
    else if (xfer.pop && at_top)  code_d = ERR_UNDERFLOW;
    else if (xfer.wr)             code_d = ERR_BAD_WRITE;
    else                          code_d = ERR_BAD_READ;
  end

  lsu_stack_ptr #(.RAM_WORDS (RAM_WORDS)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (go && xfer.pop),
    .dec_i      (go && xfer.push),
    .sp_o       (sp),
    .at_floor_o (at_floor),
    .at_top_o   (at_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      wb_en_o     <= 1'b0;
      wb_sel_o    <= '0;
      wb_data_o   <= '0;
      err_o       <= 1'b0;
      err_code_o  <= '0;
    end else begin
      mem_rd_o    <= go && xfer.rd;
      mem_wr_o    <= go && xfer.wr;
      mem_addr_o  <= (go && (xfer.rd || xfer.wr)) ? xfer.addr : '0;
      mem_wdata_o <= (go && xfer.wr) ? xfer.wdata : '0;
      wb_en_o     <= go && xfer.wb_en;
      wb_sel_o    <= go ? xfer.wb_sel : WB_IMM;
      wb_data_o   <= go ? xfer.wb_data : '0;
      err_o       <= fault;
      err_code_o  <= fault ? code_d : '0;
    end
  end

  assign sp_o = sp;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R4
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!mem_rd_o && !mem_wr_o && !wb_en_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!mem_rd_o && !mem_wr_o && !wb_en_o && !err_o)); // R13
  AST_IDLE_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sp_o)); // R13
  AST_FAULT_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> $stable(sp_o)); // R8
endmodule

// File: tb/lsu_stack_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_stack_unit_tb_top;
  localparam logic [31:0] RAM_W  = 32'd16;
  localparam logic [31:0] BIOS_B = 32'h1000_0000, BIOS_W = 32'h0010_0000;
  localparam logic [31:0] CART_B = 32'h2000_0000, CART_W = 32'h0800_0000;
  localparam logic [31:0] CARD_B = 32'h3000_0000, CARD_W = 32'h0004_0000;

  logic        clk = 1'b0, rst_ni = 1'b0, valid = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  mode = '0;
  logic [31:0] r1 = '0, r2 = '0, imm = '0;
  logic        mem_rd, mem_wr, wb_en, err;
  logic [31:0] mem_addr, mem_wdata, wb_data, sp;
  logic [1:0]  wb_sel;
  logic [3:0]  err_code;

  int checks = 0, errors = 0;
  logic [31:0] sp_m;

  typedef struct {
    logic rd, wr, wb, er;
    logic [31:0] addr, wdata, wbd, spv;
    logic [1:0] sel;
    logic [3:0] code;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lsu_stack_unit #(
    .RAM_WORDS (RAM_W), .BIOS_BASE (BIOS_B), .BIOS_WORDS (BIOS_W),
    .CART_BASE (CART_B), .CART_WORDS (CART_W),
    .CARD_BASE (CARD_B), .CARD_WORDS (CARD_W)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid), .op_i (op), .mode_i (mode),
    .reg1_i (r1), .reg2_i (r2), .imm_i (imm),
    .mem_rd_o (mem_rd), .mem_wr_o (mem_wr), .mem_addr_o (mem_addr),
    .mem_wdata_o (mem_wdata), .wb_en_o (wb_en), .wb_sel_o (wb_sel),
    .wb_data_o (wb_data), .err_o (err), .err_code_o (err_code), .sp_o (sp)
  );

  function automatic logic rd_ok(logic [31:0] a);
    return (a < RAM_W) || (a >= BIOS_B && a - BIOS_B < BIOS_W) ||
           (a >= CART_B && a - CART_B < CART_W) || (a >= CARD_B && a - CARD_B < CARD_W);
  endfunction

  function automatic logic wr_ok(logic [31:0] a);
    return (a < RAM_W) || (a >= CARD_B && a - CARD_B < CARD_W);
  endfunction

  task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic issue(logic [1:0] o, logic [2:0] m, logic [31:0] a1, logic [31:0] a2,
                       logic [31:0] im, string tag);
    exp_t e;
    @(negedge clk);
    valid = 1'b1; op = o; mode = m; r1 = a1; r2 = a2; imm = im;
    e = '{rd:0, wr:0, wb:0, er:0, addr:0, wdata:0, wbd:0, spv:sp_m, sel:0, code:0, tag:tag};
    case (o)
      2'd0: case (m)
        3'd0: begin e.wb = 1; e.sel = 0; e.wbd = im; end
        3'd1: begin e.wb = 1; e.sel = 1; e.wbd = a2; end
        3'd2, 3'd3, 3'd4: begin
          e.rd = 1; e.wb = 1; e.sel = 2;
          e.addr = (m == 2) ? im : (m == 3) ? a2 : a2 + im;
        end
        default: begin
          e.wr = 1; e.wdata = a2;
          e.addr = (m == 5) ? im : (m == 6) ? a1 : a1 + im;
        end
      endcase
      2'd1: begin e.wb = 1; e.sel = 3; e.wbd = a2 + im; end
      2'd2: begin
        if (sp_m == 0) begin e.er = 1; e.code = 4; end
        else begin e.wr = 1; e.addr = sp_m - 1; e.wdata = a1; sp_m = sp_m - 1; e.spv = sp_m; end
      end
      default: begin
        if (sp_m == RAM_W - 1) begin e.er = 1; e.code = 5; end
        else begin e.rd = 1; e.wb = 1; e.sel = 2; e.addr = sp_m; sp_m = sp_m + 1; e.spv = sp_m; end
      end
    endcase
    if (o == 2'd0 && e.rd && !rd_ok(e.addr)) begin
      e.rd = 0; e.wb = 0; e.er = 1; e.code = 0;
    end
    if (o == 2'd0 && e.wr && !wr_ok(e.addr)) begin
      e.wr = 0; e.er = 1; e.code = 1;
    end
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    valid = 1'b0; op = 2'd2; r1 = 32'hDEAD_BEEF;
    e = '{rd:0, wr:0, wb:0, er:0, addr:0, wdata:0, wbd:0, spv:sp_m, sel:0, code:0, tag:tag};
    q.push_back(e);
  endtask

  // monitor: one result per cycle, one register of latency
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (mem_rd !== e.rd) fail(e.tag, "mem_rd", 32'(mem_rd), 32'(e.rd));
        if (mem_wr !== e.wr) fail(e.tag, "mem_wr", 32'(mem_wr), 32'(e.wr));
        if ((e.rd || e.wr) && mem_addr !== e.addr) fail(e.tag, "mem_addr", mem_addr, e.addr);
        if (e.wr && mem_wdata !== e.wdata) fail(e.tag, "mem_wdata", mem_wdata, e.wdata);
        if (wb_en !== e.wb) fail(e.tag, "wb_en", 32'(wb_en), 32'(e.wb));
        if (e.wb && wb_sel !== e.sel) fail(e.tag, "wb_sel", 32'(wb_sel), 32'(e.sel));
        if (e.wb && e.sel != 2 && wb_data !== e.wbd) fail(e.tag, "wb_data", wb_data, e.wbd);
        if (err !== e.er) fail(e.tag, "err", 32'(err), 32'(e.er));
        if (e.er && err_code !== e.code) fail(e.tag, "err_code", 32'(err_code), 32'(e.code));
        if (sp !== e.spv) fail(e.tag, "sp", sp, e.spv);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sp_m = RAM_W - 1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    checks++; // R1
    if (sp !== RAM_W - 1) fail("R1", "sp", sp, RAM_W - 1);
    if (mem_rd || mem_wr || wb_en || err)
      fail("R1", "strobes", {mem_rd, mem_wr, wb_en, err}, 0);

    issue(0, 0, 32'h11, 32'h22, 32'h1234_5678, "R2");
    issue(0, 1, 32'h11, 32'hCAFE_0001, 32'h99, "R2");
    issue(0, 2, 32'h3, 32'h4, 32'h5, "R3");
    issue(0, 3, 32'h3, 32'h7, 32'h5, "R3");
    issue(0, 4, 32'h3, 32'h2, 32'h6, "R3");
    issue(0, 4, 32'h3, 32'hFFFF_FFFF, 32'h3, "R3_wrap");
    issue(0, 5, 32'h1, 32'hAAAA_5555, 32'h9, "R4");
    issue(0, 6, 32'hA, 32'h1357_9BDF, 32'h0, "R4");
    issue(0, 7, 32'h2, 32'h0F0F_0F0F, 32'h8, "R4");
    issue(1, 0, 32'h1, 32'h1000, 32'h24, "R5");
    issue(1, 0, 32'h1, 32'h8000_0000, 32'h8000_0001, "R5_wrap");
    idle("R13");
    issue(3, 0, 32'h0, 32'h0, 32'h0, "R9");
    for (int i = 0; i < 15; i++) issue(2, 0, 32'h100 + i, 32'h0, 32'h0, "R6");
    issue(2, 0, 32'h777, 32'h0, 32'h0, "R8");
    idle("R13_floor");
    issue(3, 0, 32'h0, 32'h0, 32'h0, "R7");
    issue(3, 0, 32'h0, 32'h0, 32'h0, "R7");
    issue(0, 2, 32'h0, 32'h0, 32'h0000_0010, "R10_ram_end");
    issue(0, 3, 32'h0, 32'h4000_0000, 32'h0, "R10_gap");
    issue(0, 4, 32'h0, CART_B, CART_W, "R10_cart_end");
    issue(0, 2, 32'h0, 32'h0, BIOS_B + 5, "R12_bios");
    issue(0, 3, 32'h0, CART_B + 32'h0123_4567, 32'h0, "R12_cart");
    issue(0, 2, 32'h0, 32'h0, CARD_B + CARD_W - 1, "R12_card_rd");
    issue(0, 5, 32'h0, 32'h55, CARD_B + 32'h10, "R12_card_wr");
    issue(0, 5, 32'h0, 32'h55, BIOS_B + 5, "R11_bios");
    issue(0, 6, CART_B, 32'h55, 32'h0, "R11_cart");
    issue(0, 7, 32'h3000_0000, 32'h55, CARD_W, "R11_card_end");
    issue(0, 5, 32'h0, 32'h55, 32'h10, "R11_ram_end");
    idle("R13");
    idle("R13");
    wait (q.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule